// File: doc/BRIEF.md
# Prescaled Compare-Match Timer

This block is a small counter that advances on enables carved out of the system clock by a free-running prescaler. A 3-bit clock-select field picks one of seven division ratios or stops the count. The running count is compared with a programmable compare value. The comparison raises a sticky compare flag and can drive a single waveform pin. In clear-on-match mode the compare value becomes the top of the count, so the block acts as a programmable period generator.

A host reaches three registers through a plain single-cycle register port: control, count and compare. A separate flag-clear pin clears the flag. The port has no stream interface and no back-pressure. Every write completes in the cycle it is presented, and reads are combinational from the read address.

The control register packs the following fields. Bit 7 is a write-only force strobe. Bit 6 is the PWM-class mode bit. Bits 5:4 hold the pin action. Bit 3 is the clear-on-match bit. Bits 2:0 hold the clock select. A write with the force bit set, while the written bit 6 is 0, applies the pin action at once, without waiting for a real match.

Top module: `cmp_timer`

## Requirements
- R1: After reset the control, count and compare registers read 0, `cmp_flag` is 0 and `wave_out` is 0.
- R2: The prescaler is a free-running counter that is 0 after reset and increments every clock. A timer tick occurs on a clock where its low log2(N) bits are all ones. Clock select 001..111 gives N = 1, 8, 32, 64, 128, 256, 1024. Clock select 000 gives no ticks, and the count holds.
- R3: In normal mode (control bit 3 = 0 or bit 6 = 1) each tick adds one to the count, which wraps from 0xFF to 0x00.
- R4: A tick that finds the count already equal to the compare value is a match, so the flag rises one tick after equality is reached. A match sets `cmp_flag`, which then holds until a cycle with `flag_clr` = 1 and no match. A match wins over a clear in the same cycle.
- R5: Clear-on-match mode is control bit 3 = 1 with bit 6 = 0. In this mode the count goes to 0 on a matching tick, in the same cycle the flag is set.
- R6: The pin action field (control bits 5:4) acts on each match while bit 6 is 0. The encodings are 00 hold, 01 toggle, 10 drive 0 and 11 drive 1. While bit 6 is 1, matches leave `wave_out` unchanged.
- R7: A control write with bit 7 = 1 and written bit 6 = 0 applies the written bits 5:4 action to `wave_out` on that edge. It does not change `cmp_flag` or the count. With written bit 6 = 1, the force has no effect.
- R8: The control register reads back bits 6:0 as written, and bit 7 always reads 0.
- R9: A count write takes effect over a tick in the same cycle. It also suppresses the match on the next tick, even when the written value equals the compare value.
- R10: Register addresses are 0 control, 1 count, 2 compare. Address 3 reads 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Write register address |
| bus_wdata | input | CNT_W | Write data |
| rd_addr | input | 2 | Read register address |
| rd_data | output | CNT_W | Combinational read data |
| flag_clr | input | 1 | Clears the compare flag |
| cmp_flag | output | 1 | Sticky compare flag |
| wave_out | output | 1 | Waveform pin |

## Verification
The bench builds the block with the defaults CNT_W = 8 and PRE_W = 10. The 10-bit prescaler makes the largest ratio of 1024 reachable, and the 8-bit count wraps within a few hundred ticks. A cycle-level reference model, written from the requirements, is compared against the ports after each table run across all seven ratios and all modes. Directed sequences cover the exact clear-on-match cycle, the suppressed match after a count write, force gating by mode, and the unused address.

// File: rtl/cmp_timer_pkg.sv
`timescale 1ns/1ps
package cmp_timer_pkg;

  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_COUNT = 2'd1,
    REG_CMP   = 2'd2,
    REG_NONE  = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    ACT_HOLD   = 2'd0,
    ACT_TOGGLE = 2'd1,
    ACT_CLEAR  = 2'd2,
    ACT_SET    = 2'd3
  } pin_act_e;

  // stored control bits 6:0; bit 7 (force) is never stored
  typedef struct packed {
    logic       pwm;
    pin_act_e   act;
    logic       ctc;
    logic [2:0] cs;
  } ctrl_t;

  // log2 of the division ratio for each clock-select code
  function automatic int unsigned cs_shift(input logic [2:0] cs);
    case (cs)
      3'd2:    return 3;
      3'd3:    return 5;
      3'd4:    return 6;
      3'd5:    return 7;
      3'd6:    return 8;
      3'd7:    return 10;
      default: return 0;
    endcase
  endfunction

  function automatic logic apply_act(input pin_act_e a, input logic cur);
    case (a)
      ACT_TOGGLE: return ~cur;
      ACT_CLEAR:  return 1'b0;
      ACT_SET:    return 1'b1;
      default:    return cur;
    endcase
  endfunction

endpackage

// File: rtl/cmp_timer_prescaler.sv
`timescale 1ns/1ps
module cmp_timer_prescaler
  import cmp_timer_pkg::*;
#(
  parameter int unsigned PRE_W = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] cs,
  output logic       tick
);

  logic [PRE_W-1:0] pre_q;
  logic [7:0]       hit;

  always_ff @(posedge clk) begin
    if (rst) pre_q <= '0;
    else     pre_q <= pre_q + 1'b1;
  end

  assign hit[0] = 1'b0;

  for (genvar g = 1; g < 8; g++) begin : g_tap
    localparam int unsigned    SH   = cs_shift(3'(g));
    localparam logic [PRE_W-1:0] MASK = PRE_W'((64'd1 << SH) - 64'd1);
    assign hit[g] = ((pre_q & MASK) == MASK);
  end

  assign tick = hit[cs];

endmodule

// File: rtl/cmp_timer_core.sv
`timescale 1ns/1ps
module cmp_timer_core #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             ctc_en,
  input  logic [CNT_W-1:0] ocr,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] cnt,
  output logic             match,
  output logic             flag
);

  logic sup_q;  // blocks the match on the first tick after a count write

  assign match = tick && !cnt_wr && !sup_q && (cnt == ocr);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      sup_q <= 1'b0;
    end else if (cnt_wr) begin
      cnt   <= cnt_wdata;
      sup_q <= 1'b1;
    end else if (tick) begin
      sup_q <= 1'b0;
      if (match && ctc_en) cnt <= '0;
      else                 cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           flag <= 1'b0;
    else if (match)    flag <= 1'b1;
    else if (flag_clr) flag <= 1'b0;
  end

endmodule

// File: rtl/cmp_timer_wave.sv
`timescale 1ns/1ps
module cmp_timer_wave
  import cmp_timer_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     match,
  input  logic     pwm,
  input  pin_act_e act,
  input  logic     force_hit,
  input  pin_act_e force_act,
  output logic     wave
);

  always_ff @(posedge clk) begin
    if (rst)                 wave <= 1'b0;
    else if (force_hit)      wave <= apply_act(force_act, wave);
    else if (match && !pwm)  wave <= apply_act(act, wave);
  end

endmodule

// File: rtl/cmp_timer.sv
`timescale 1ns/1ps
module cmp_timer
  import cmp_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned PRE_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  input  logic [1:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  input  logic             flag_clr,
  output logic             cmp_flag,
  output logic             wave_out
);

  localparam int unsigned CTRL_W    = $bits(ctrl_t);
  localparam int unsigned FORCE_BIT = CTRL_W;
  localparam int unsigned PWM_BIT   = CTRL_W - 1;

  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] ocr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ctrl_wr, cnt_wr, ocr_wr;
  logic             force_hit, tick, match, ctc_en;
  ctrl_t            wr_ctrl;

  assign ctrl_wr = bus_wr && (reg_sel_e'(bus_addr) == REG_CTRL);
  assign cnt_wr  = bus_wr && (reg_sel_e'(bus_addr) == REG_COUNT);
  assign ocr_wr  = bus_wr && (reg_sel_e'(bus_addr) == REG_CMP);
  assign wr_ctrl = ctrl_t'(bus_wdata[CTRL_W-1:0]);

  // force acts only when the mode bits written alongside it are non-PWM
  assign force_hit = ctrl_wr && bus_wdata[FORCE_BIT] && !bus_wdata[PWM_BIT];
  assign ctc_en    = ctrl_q.ctc && !ctrl_q.pwm;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      ocr_q  <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= wr_ctrl;
      if (ocr_wr)  ocr_q  <= bus_wdata;
    end
  end

  always_comb begin
    case (reg_sel_e'(rd_addr))
      REG_CTRL:  rd_data = CNT_W'(ctrl_q);
      REG_COUNT: rd_data = cnt_q;
      REG_CMP:   rd_data = ocr_q;
      default:   rd_data = '0;
    endcase
  end

  cmp_timer_prescaler #(.PRE_W(PRE_W)) pre_i (
    .clk  (clk),
    .rst  (rst),
    .cs   (ctrl_q.cs),
    .tick (tick)
  );

  cmp_timer_core #(.CNT_W(CNT_W)) core_i (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .ctc_en    (ctc_en),
    .ocr       (ocr_q),
    .cnt_wr    (cnt_wr),
    .cnt_wdata (bus_wdata),
    .flag_clr  (flag_clr),
    .cnt       (cnt_q),
    .match     (match),
    .flag      (cmp_flag)
  );

  cmp_timer_wave wave_i (
    .clk       (clk),
    .rst       (rst),
    .match     (match),
    .pwm       (ctrl_q.pwm),
    .act       (ctrl_q.act),
    .force_hit (force_hit),
    .force_act (wr_ctrl.act),
    .wave      (wave_out)
  );

endmodule

// File: rtl/cmp_timer_chk.sv
`timescale 1ns/1ps
module cmp_timer_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic [2:0]       cs,
  input logic             cnt_wr,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] bus_wdata,
  input logic             ctc_en,
  input logic             match,
  input logic             pwm,
  input logic             force_hit,
  input logic             flag_clr,
  input logic             cmp_flag,
  input logic             wave_out,
  input logic [1:0]       rd_addr,
  input logic [CNT_W-1:0] rd_data
);

  p_stopped_r2: assert property (@(posedge clk) disable iff (rst)
    (cs == 3'd0 && !cnt_wr) |=> $stable(cnt));

  p_flag_on_tick_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(cmp_flag) |-> $past(tick));

  p_flag_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (flag_clr && !match) |=> !cmp_flag);

  p_ctc_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    (match && ctc_en) |=> (cnt == '0));

  p_wave_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (!force_hit && !(match && !pwm)) |=> $stable(wave_out));

  p_force_bit_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_addr == 2'd0) |-> (rd_data[7] == 1'b0));

  p_cnt_write_r9: assert property (@(posedge clk) disable iff (rst)
    cnt_wr |=> (cnt == $past(bus_wdata)));

endmodule

bind cmp_timer cmp_timer_chk #(.CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .tick      (tick),
  .cs        (ctrl_q.cs),
  .cnt_wr    (cnt_wr),
  .cnt       (cnt_q),
  .bus_wdata (bus_wdata),
  .ctc_en    (ctc_en),
  .match     (match),
  .pwm       (ctrl_q.pwm),
  .force_hit (force_hit),
  .flag_clr  (flag_clr),
  .cmp_flag  (cmp_flag),
  .wave_out  (wave_out),
  .rd_addr   (rd_addr),
  .rd_data   (rd_data)
);

// File: tb/cmp_timer_tb_top.sv
`timescale 1ns/1ps
module cmp_timer_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [1:0] rd_addr = 2'd0;
  logic [7:0] rd_data;
  logic       flag_clr = 1'b0;
  logic       cmp_flag, wave_out;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  cmp_timer dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rd_addr(rd_addr), .rd_data(rd_data),
    .flag_clr(flag_clr), .cmp_flag(cmp_flag), .wave_out(wave_out)
  );

  // reference model written from the requirements
  logic [9:0] m_pre;
  logic [7:0] m_cnt, m_ocr;
  logic [6:0] m_ctrl;
  logic       m_flag, m_wave, m_sup;

  function automatic logic pin(input logic [1:0] c, input logic w);
    case (c)
      2'd1:    return ~w;
      2'd2:    return 1'b0;
      2'd3:    return 1'b1;
      default: return w;
    endcase
  endfunction

  always @(posedge clk) begin : model
    logic [9:0] msk;
    logic tk, mt, wc;
    if (rst) begin
      m_pre <= '0; m_cnt <= '0; m_ocr <= '0; m_ctrl <= '0;
      m_flag <= 1'b0; m_wave <= 1'b0; m_sup <= 1'b0;
    end else begin
      case (m_ctrl[2:0])
        3'd2: msk = 10'd7;
        3'd3: msk = 10'd31;
        3'd4: msk = 10'd63;
        3'd5: msk = 10'd127;
        3'd6: msk = 10'd255;
        3'd7: msk = 10'd1023;
        default: msk = 10'd0;
      endcase
      tk = (m_ctrl[2:0] != 3'd0) && ((m_pre & msk) == msk);
      wc = bus_wr && bus_addr == 2'd1;
      mt = tk && !wc && !m_sup && (m_cnt == m_ocr);
      m_pre <= m_pre + 10'd1;
      if (wc) begin
        m_cnt <= bus_wdata; m_sup <= 1'b1;
      end else if (tk) begin
        m_sup <= 1'b0;
        m_cnt <= (mt && m_ctrl[3] && !m_ctrl[6]) ? 8'd0 : m_cnt + 8'd1;
      end
      if (mt) m_flag <= 1'b1;
      else if (flag_clr) m_flag <= 1'b0;
      if (bus_wr && bus_addr == 2'd0 && bus_wdata[7] && !bus_wdata[6])
        m_wave <= pin(bus_wdata[5:4], m_wave);
      else if (mt && !m_ctrl[6])
        m_wave <= pin(m_ctrl[5:4], m_wave);
      if (bus_wr && bus_addr == 2'd0) m_ctrl <= bus_wdata[6:0];
      if (bus_wr && bus_addr == 2'd2) m_ocr <= bus_wdata;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    rd_addr = a;
    #0.5;
    d = rd_data;
  endtask

  task automatic clr_flag();
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
  endtask

  // {ctrl, compare, start count, wait cycles}
  localparam logic [39:0] VEC [7] = '{
    {8'h11, 8'h0A, 8'h00, 16'd40},    // R3 R4 R6 ratio 1 toggle
    {8'h1A, 8'h04, 8'h00, 16'd123},   // R2 R5 ratio 8 clear-on-match
    {8'h23, 8'hFA, 8'hF0, 16'd700},   // R3 ratio 32 wrap, drive 0
    {8'h3C, 8'h00, 8'h00, 16'd333},   // R5 ratio 64 top of zero
    {8'h55, 8'h02, 8'h00, 16'd900},   // R6 pwm bit holds pin
    {8'h1E, 8'h01, 8'h00, 16'd1500},  // R2 ratio 256
    {8'h07, 8'h01, 8'h00, 16'd2600}   // R2 ratio 1024
  };

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, d); check("R1 ctrl", d, 0);
    rd(2'd1, d); check("R1 count", d, 0);
    rd(2'd2, d); check("R1 compare", d, 0);
    check("R1 flag", cmp_flag, 0);
    check("R1 wave", wave_out, 0);

    // R5 exact clear-on-match cycle, ratio 1, top 3, toggle
    wr(2'd2, 8'd3);
    wr(2'd0, 8'h19);
    wr(2'd1, 8'd0);
    repeat (3) @(negedge clk);
    rd(2'd1, d); check("R5 at top", d, 3);
    check("R4 no flag at equality", cmp_flag, 0);
    @(negedge clk);
    rd(2'd1, d); check("R5 wrapped to 0", d, 0);
    check("R4 flag on following tick", cmp_flag, 1);
    check("R6 toggle on match", wave_out, 1);

    // R4 clear, R9 suppression
    wr(2'd0, 8'h00);
    clr_flag();
    check("R4 flag cleared", cmp_flag, 0);
    wr(2'd2, 8'd5);
    wr(2'd1, 8'd5);
    wr(2'd0, 8'h01);
    @(negedge clk);
    rd(2'd1, d); check("R9 count advanced", d, 6);
    check("R9 match suppressed", cmp_flag, 0);
    wr(2'd1, 8'h80);
    rd(2'd1, d); check("R9 write beats tick", d, 8'h80);

    // R2 stopped
    wr(2'd0, 8'h00);
    rd(2'd1, d);
    repeat (20) @(negedge clk);
    begin
      logic [7:0] d2;
      rd(2'd1, d2); check("R2 stopped holds", d2, d);
    end

    // R3 wrap
    wr(2'd2, 8'h10);
    wr(2'd1, 8'hFE);
    wr(2'd0, 8'h01);
    @(negedge clk);
    @(negedge clk);
    rd(2'd1, d); check("R3 wrap FF to 00", d, 0);

    // R7 R8 force strobe
    wr(2'd0, 8'h00);
    rd(2'd1, d);
    wr(2'd0, 8'hA0);
    check("R7 force drive 0", wave_out, 0);
    check("R7 force leaves flag", cmp_flag, 0);
    begin
      logic [7:0] d2;
      rd(2'd1, d2); check("R7 force leaves count", d2, d);
    end
    rd(2'd0, d); check("R8 force reads 0", d, 8'h20);
    wr(2'd0, 8'hF0);
    check("R7 force ignored in pwm", wave_out, 0);
    wr(2'd0, 8'hB0);
    check("R7 force drive 1", wave_out, 1);
    wr(2'd0, 8'h90);
    check("R7 force toggle", wave_out, 0);

    // R10 unused address
    wr(2'd2, 8'h33);
    wr(2'd3, 8'h55);
    rd(2'd3, d); check("R10 addr3 reads 0", d, 0);
    rd(2'd2, d); check("R10 compare untouched", d, 8'h33);
    rd(2'd0, d); check("R10 ctrl untouched", d, 8'h10);

    // table walk against the model
    for (int i = 0; i < 7; i++) begin
      wr(2'd0, 8'h00);
      clr_flag();
      wr(2'd2, VEC[i][31:24]);
      wr(2'd1, VEC[i][23:16]);
      wr(2'd0, VEC[i][39:32]);
      repeat (int'(VEC[i][15:0])) @(negedge clk);
      rd(2'd1, d);
      check($sformatf("R2 R3 R5 table %0d count", i), d, m_cnt);
      check($sformatf("R4 table %0d flag", i), cmp_flag, m_flag);
      check($sformatf("R6 table %0d wave", i), wave_out, m_wave);
    end

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule